// File: doc/BRIEF.md
# Chained Slice Synchronous Up-Counter

This block is a wide synchronous binary up-counter assembled from identical 4-bit counter slices. Every slice is clocked by the same global clock and carries its own synchronous controls: an active-low clear, an active-low parallel load, and two count enables that must both be high before the slice advances. Each slice also produces a carry-out. This carry-out is high when the slice holds all ones and its chained enable is high.

The slices are joined so that no carry can stick. A single run enable from the top goes to the gate enable of every slice. The chained enable of slice 0 is tied high, and the chained enable of every higher slice is the carry-out of the slice below it. The top presents a shared clear, a shared load with full-width parallel data, the full count, and a terminal carry for cascading further.

The number of slices is a parameter and defaults to three, which gives 12 bits. In the count, bits [4k+3:4k] belong to slice k, and slice 0 is the least significant.

Top module: `chained_counter`

## Requirements
- R1: When `clr_n` is low at a rising clock edge, every slice becomes zero after that edge, whatever the states of `ld_n`, `run_en` and `ld_val`.
- R2: When `clr_n` is high and `ld_n` is low at a rising edge, `cnt_val` takes the value of `ld_val` after that edge, whatever the state of `run_en`.
- R3: With `clr_n` high, `ld_n` high and `run_en` high, `cnt_val` rises by exactly one per edge. After the all-ones value it becomes zero.
- R4: With `clr_n` high, `ld_n` high and `run_en` low, `cnt_val` does not change at the edge.
- R5: A slice advances only when its gate enable and its chained enable are both high. A slice's carry-out is high only when its four bits are all ones and its chained enable is high. As a result, slice k>0 advances on exactly those counting edges where all bits below it are ones.
- R6: `term_cy` is high exactly when `cnt_val` is all ones and `run_en` is high. It is a combinational function of the current count and `run_en`.
- R7: An upper slice that reads 1111 while the slices below it are not all ones leaves the slices above it unchanged. For example, from 12'h0F0 (and from 12'hFF0) the upper slices stay put while the lowest slice counts through 0 to 15.
- R8: Clear and load act on all slices in the same edge, and they do so whether `run_en` is high or low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low |
| run_en | input | 1 | Run enable, drives the gate enable of every slice |
| ld_val | input | 4*NUM_SLICES | Parallel load data, slice 0 in the low bits |
| cnt_val | output | 4*NUM_SLICES | Current count, slice 0 in the low bits |
| term_cy | output | 1 | Terminal carry: count all ones and run enabled |

## Verification
The bench goes after three things: slice boundaries (loads of 0x0EC, 0x0F0 and 0xFF0), the wrap at all ones, and stuck carries. A design that routed the chain carry into the gate enable would let the upper slices advance on every cycle while the lowest slice rolled from 0 to 15. A design whose carry ignored the chained enable would advance middle slices too early. Random run-enable gaps check that a slice holds when either enable is low. A clear or load issued together with counting, or with the run enable low, checks priority: a design that let the count win, or that required the run enable for a load, would show a wrong value one edge later. The terminal carry is compared on every cycle against the expected count and the run enable. This catches a carry that ignores the run enable or that is registered instead of combinational.

// File: rtl/slicectr_pkg.sv
package slicectr_pkg;

  localparam int SLICE_W = 4;

  typedef logic [SLICE_W-1:0] nib_t;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } act_e;

  // Priority decode: clear, then load, then count, else hold.
  function automatic act_e pick_act(input logic clr_n, input logic ld_n,
                                    input logic gate, input logic cy_in);
    act_e a;
    if (!clr_n)               a = ACT_CLEAR;
    else if (!ld_n)           a = ACT_LOAD;
    else if (gate && cy_in)   a = ACT_COUNT;
    else                      a = ACT_HOLD;
    return a;
  endfunction

  // Next value of one slice for a chosen action.
  function automatic nib_t next_nib(input act_e a, input nib_t cur,
                                    input nib_t d);
    nib_t n;
    case (a)
      ACT_CLEAR: n = '0;
      ACT_LOAD:  n = d;
      ACT_COUNT: n = cur + nib_t'(1);
      default:   n = cur;
    endcase
    return n;
  endfunction

  // Slice at its top value.
  function automatic logic nib_full(input nib_t v);
    return &v;
  endfunction

endpackage

// File: rtl/cnt_slice.sv
module cnt_slice
  import slicectr_pkg::*;
(
  input  logic clk,
  input  logic clr_n,
  input  logic ld_n,
  input  logic gate,
  input  logic cy_in,
  input  nib_t ld_d,
  output nib_t q,
  output logic cy_out
);

  nib_t q_r;
  act_e act;
  logic do_clear, do_load, do_count, do_hold;
  logic primed = 1'b0;

  always_comb act = pick_act(clr_n, ld_n, gate, cy_in);

  assign do_clear = (act == ACT_CLEAR);
  assign do_load  = (act == ACT_LOAD);
  assign do_count = (act == ACT_COUNT);
  assign do_hold  = (act == ACT_HOLD);

  always_ff @(posedge clk) begin
    q_r <= next_nib(act, q_r, ld_d);
  end

  always_ff @(posedge clk) begin
    if (!clr_n) primed <= 1'b1;
  end

  assign q      = q_r;
  assign cy_out = nib_full(q_r) & cy_in;

  // R1
  slice_clear_chk: assert property (@(posedge clk)
    do_clear |=> (q == '0));

  // R2
  slice_load_chk: assert property (@(posedge clk) disable iff (!primed)
    do_load |=> (q == $past(ld_d)));

  // R5
  slice_step_chk: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && ld_n && gate && cy_in) |=> (q == $past(q) + nib_t'(1)));

  // R5
  slice_hold_chk: assert property (@(posedge clk) disable iff (!primed)
    do_hold |=> $stable(q));

  // R5
  slice_cy_chk: assert property (@(posedge clk) disable iff (!primed)
    cy_out |-> (cy_in && q == '1));

  slice_onehot_chk: assert property (@(posedge clk)
    $onehot({do_clear, do_load, do_count, do_hold}));

endmodule

// File: rtl/slice_chain.sv
module slice_chain
  import slicectr_pkg::*;
#(
  parameter int NUM_SLICES = 3,
  localparam int W = NUM_SLICES * SLICE_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         gate,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt_val,
  output logic         cy_top
);

  logic [NUM_SLICES:0] cy;
  logic primed = 1'b0;

  assign cy[0] = 1'b1;

  always_ff @(posedge clk) begin
    if (!clr_n) primed <= 1'b1;
  end

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    nib_t q_k;
    cnt_slice u_slice (
      .clk    (clk),
      .clr_n  (clr_n),
      .ld_n   (ld_n),
      .gate   (gate),
      .cy_in  (cy[k]),
      .ld_d   (ld_val[k*SLICE_W +: SLICE_W]),
      .q      (q_k),
      .cy_out (cy[k+1])
    );
    assign cnt_val[k*SLICE_W +: SLICE_W] = q_k;
  end

  for (genvar k = 1; k <= NUM_SLICES; k++) begin : g_chk
    // R5
    chain_lower_full_chk: assert property (@(posedge clk) disable iff (!primed)
      cy[k] |-> (&cnt_val[k*SLICE_W-1:0]));

    // R7
    no_stuck_carry_chk: assert property (@(posedge clk) disable iff (!primed)
      (cy[k] && gate && clr_n && ld_n) |=> !cy[k]);
  end

  assign cy_top = cy[NUM_SLICES];

endmodule

// File: rtl/chained_counter.sv
module chained_counter
  import slicectr_pkg::*;
#(
  parameter int NUM_SLICES = 3,
  localparam int W = NUM_SLICES * SLICE_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         run_en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt_val,
  output logic         term_cy
);

  logic chain_cy;
  logic primed = 1'b0;

  slice_chain #(.NUM_SLICES(NUM_SLICES)) u_chain (
    .clk     (clk),
    .clr_n   (clr_n),
    .ld_n    (ld_n),
    .gate    (run_en),
    .ld_val  (ld_val),
    .cnt_val (cnt_val),
    .cy_top  (chain_cy)
  );

  assign term_cy = chain_cy & run_en;

  always_ff @(posedge clk) begin
    if (!clr_n) primed <= 1'b1;
  end

  // R1
  top_clear_chk: assert property (@(posedge clk)
    !clr_n |=> (cnt_val == '0));

  // R2
  top_load_chk: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && !ld_n) |=> (cnt_val == $past(ld_val)));

  // R3
  top_incr_chk: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && ld_n && run_en) |=> (cnt_val == $past(cnt_val) + W'(1)));

  // R4
  top_hold_chk: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && ld_n && !run_en) |=> $stable(cnt_val));

  // R6
  term_cy_chk: assert property (@(posedge clk) disable iff (!primed)
    term_cy == (run_en && (cnt_val == '1)));

endmodule

// File: tb/chained_counter_bench.sv
module chained_counter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_SLICES = 3;
  localparam int W = NUM_SLICES * 4;
  localparam logic [W-1:0] ALL1 = '1;

  logic         clk = 1'b0;
  logic         clr_n = 1'b1;
  logic         ld_n = 1'b1;
  logic         run_en = 1'b0;
  logic [W-1:0] ld_val = '0;
  logic [W-1:0] cnt_val;
  logic         term_cy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] model = '0;

  chained_counter #(.NUM_SLICES(NUM_SLICES)) u_chained_counter (
    .clk     (clk),
    .clr_n   (clr_n),
    .ld_n    (ld_n),
    .run_en  (run_en),
    .ld_val  (ld_val),
    .cnt_val (cnt_val),
    .term_cy (term_cy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // One cycle: drive at the falling edge, check the terminal carry,
  // let the rising edge happen, then compare the count.
  task automatic step(input bit c, input bit l, input bit e,
                      input logic [W-1:0] d, input string tag);
    logic [W-1:0] nxt;
    clr_n = c; ld_n = l; run_en = e; ld_val = d;
    #1;
    checks++;
    if (term_cy !== (e && model == ALL1)) begin
      errors++;
      $display("FAIL R6 (%s): term_cy=%b expected %b at count %h",
               tag, term_cy, (e && model == ALL1), model);
    end
    if (!c)      nxt = '0;
    else if (!l) nxt = d;
    else if (e)  nxt = model + 1'b1;
    else         nxt = model;
    @(posedge clk);
    model = nxt;
    @(negedge clk);
    checks++;
    if (cnt_val !== model) begin
      errors++;
      $display("FAIL %s: cnt_val=%h expected %h", tag, cnt_val, model);
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 1, 1, '0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state through clear, even with load and run asserted
    step(0, 0, 1, 12'hABC, "R1");
    step(0, 1, 0, '0, "R1");
    // R3: plain counting
    run(20, "R3");
    // R4: run enable low holds
    for (int i = 0; i < 5; i++) step(1, 1, 0, 12'h555, "R4");
    // R2 and R8: load while run enable is low
    step(1, 0, 0, 12'h0EC, "R8");
    // R5: carry from slice 0 into slice 1 at 0x0EF
    run(10, "R5");
    // R7: upper slice at 1111 over a wrapping lower slice
    step(1, 0, 1, 12'h0F0, "R2");
    run(20, "R7");
    step(1, 0, 1, 12'hFF0, "R2");
    run(20, "R7");
    // R3 and R6: full wrap through all ones, with a pause at all ones
    step(1, 0, 1, 12'hFFC, "R2");
    run(3, "R3");
    step(1, 1, 0, '0, "R6");
    step(1, 1, 0, '0, "R4");
    run(4, "R3");
    // R4 and R5: random run enable gaps across slice boundaries
    step(1, 0, 1, 12'h0F8, "R2");
    for (int i = 0; i < 400; i++) step(1, 1, 1'($urandom_range(0, 1)), '0, "R5");
    // R1: clear while counting beats load
    run(5, "R3");
    step(0, 0, 1, 12'h777, "R1");
    run(3, "R3");
    // R8: clear with run enable low, load with run enable high
    step(0, 1, 0, '0, "R8");
    step(1, 0, 1, 12'h3FF, "R8");
    run(2, "R5");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule